// File: doc/BRIEF.md
# EEPROM Page Write Load Controller

This block is the synchronous write front end of a byte-wide parallel nonvolatile memory. It watches sampled, active-low chip-enable, output-enable and write-enable lines together with an address and a data byte. Each valid write strobe drops one byte into a 64-entry page buffer and marks that byte position as loaded. Bytes can arrive in any order, and a position can be rewritten. The load phase stays open while strobes keep coming. It closes once no byte has been accepted for a parameterised window.

When the load phase closes, a timed programming phase starts. During this phase `busy` is high and new strobes are ignored. At the end of the phase, only the marked bytes are copied into a behavioural storage array. The rest of the page is left as it was. A one-cycle `prog_done` pulse marks the copy, and the block returns to idle.

Two conditions block writes. For a power-on delay after reset, every strobe is refused. Within one load phase, a strobe that names a different page from the first byte is thrown away and raises a sticky error flag. The array can be read at any time through the same address port. All timer lengths are counted in clock cycles.

Top module: `eeprom_page_loader`

## Requirements
- R1: A strobe begins only on a cycle where `ce_n` and `we_n` are both sampled low and `oe_n` is sampled high. If `oe_n` is low, a strobe never begins, and a pending strobe is dropped.
- R2: The address is taken on the cycle the strobe begins, which is the later of the two falling edges. The data byte is taken from `din` on the first cycle that either `we_n` or `ce_n` is sampled high again.
- R3: Address bits [5:0] select the byte within a page, and bits [ADDR_W-1:6] select the page. Bytes may be loaded in any order. When a position is loaded twice, the last value is kept.
- R4: Each accepted byte restarts a window of T_BLC cycles. If no byte is accepted before the window runs out, `busy` rises exactly T_BLC+1 cycles after the clock edge that ended the last accepted strobe.
- R5: Within a load phase, a strobe whose page bits differ from the first byte's page is discarded. It sets `page_err` and does not restart the window. `page_err` is cleared by the first byte accepted in the next load phase.
- R6: `busy` stays high for exactly T_WC cycles. Strobes made while `busy` is high are ignored. They neither change the array nor open a new load phase.
- R7: Programming writes only the loaded byte positions of the page. All other bytes in the array keep their values.
- R8: `prog_done` is a single-cycle pulse on the first cycle after `busy` falls. The loaded marks are cleared at the same point.
- R9: Strobes that begin within the power-on delay of T_POR cycles after reset release are ignored.
- R10: After reset, `busy`, `prog_done` and `page_err` are 0, and every array byte reads 8'hFF.
- R11: `rdata` gives the array byte at `addr`, registered one clock after `addr` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Sampled chip enable, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| addr | input | ADDR_W | Byte address (page bits above bit 5) |
| din | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered array read data |
| busy | output | 1 | Programming phase in progress |
| prog_done | output | 1 | One-cycle pulse when the page is committed |
| page_err | output | 1 | Sticky flag set by a strobe to a foreign page |

## Verification
The internal faults that matter can all be seen at the ports, and each one has a known cycle at which it shows.

- A window counter that reloads wrongly, or that a foreign-page strobe restarts, moves the rising edge of `busy` away from its fixed distance of T_BLC+1 cycles after the last accepted strobe.
- A wrong programming count shifts the falling edge of `busy` and the `prog_done` pulse.
- A stale mask or a wrong page register shows up as wrong bytes in a full read-back of the page and its neighbour. That read-back happens right after `prog_done`.
- A bad address or data latch point shows up in the same read-back. The bench moves `addr` and `din` away from their correct values between the two edges of every strobe, so a latch taken at the wrong edge stores the wrong byte.

// File: rtl/plc_pkg.sv
package plc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } plc_state_e;

  // position of a byte inside its page
  function automatic int unsigned byte_sel(input int unsigned a, input int unsigned off_w);
    return a & ((32'd1 << off_w) - 32'd1);
  endfunction

  // page index above the in-page offset
  function automatic int unsigned page_sel(input int unsigned a, input int unsigned off_w);
    return a >> off_w;
  endfunction

endpackage

// File: rtl/plc_timer.sv
module plc_timer #(
  parameter int unsigned LEN        = 16,
  parameter bit          START_FULL = 1'b0,
  parameter int unsigned CW         = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam logic [CW-1:0] TOP = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= START_FULL ? TOP : '0;
    else if (load)
      cnt <= TOP;
    else if (run && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/plc_strobe.sv
module plc_strobe #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              allow,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              evt,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [DATA_W-1:0] evt_data
);
  logic act, act_q, armed;
  logic start_w, rise_w, abort_w;
  logic [ADDR_W-1:0] lat_addr;

  assign act     = !ce_n && !we_n && oe_n;
  assign start_w = act && !act_q && allow && !armed;
  assign rise_w  = armed && (ce_n || we_n);
  assign abort_w = armed && !rise_w && !oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      armed    <= 1'b0;
      lat_addr <= '0;
      evt      <= 1'b0;
      evt_addr <= '0;
      evt_data <= '0;
    end else begin
      act_q <= act;
      evt   <= rise_w;
      if (start_w) begin
        armed    <= 1'b1;
        lat_addr <= addr;
      end else if (rise_w || abort_w) begin
        armed <= 1'b0;
      end
      if (rise_w) begin
        evt_addr <= lat_addr;
        evt_data <= din;
      end
    end
  end

  // R1
  arm_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(oe_n) && !$past(we_n) && !$past(ce_n)));

  // R2
  evt_from_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(armed));
endmodule

// File: rtl/plc_page_buf.sv
module plc_page_buf #(
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BYTES  = 1 << OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [OFF_W-1:0]        wr_off,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    clr,
  output logic [BYTES-1:0]        vmask,
  output logic [BYTES*DATA_W-1:0] bdata
);
  for (genvar i = 0; i < BYTES; i++) begin : g_slot
    logic hit;
    assign hit = wr && (wr_off == OFF_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vmask[i]                  <= 1'b0;
        bdata[i*DATA_W +: DATA_W] <= '0;
      end else if (clr) begin
        vmask[i] <= 1'b0;
      end else if (hit) begin
        vmask[i]                  <= 1'b1;
        bdata[i*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/plc_array.sv
module plc_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned DATA_W = 8,
  parameter logic [7:0]  ERASED = 8'hFF,
  parameter int unsigned BYTES  = 1 << OFF_W,
  parameter int unsigned PAGE_W = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic [PAGE_W-1:0]       cpage,
  input  logic [BYTES-1:0]        cmask,
  input  logic [BYTES*DATA_W-1:0] cdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [DATA_W-1:0]       rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= DATA_W'(ERASED);
      rdata <= '0;
    end else begin
      for (int i = 0; i < BYTES; i++) begin
        if (commit && cmask[i])
          mem[{cpage, OFF_W'(i)}] <= cdata[i*DATA_W +: DATA_W];
      end
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_BLC  = 40,
  parameter int unsigned T_WC   = 120,
  parameter int unsigned T_POR  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              prog_done,
  output logic              page_err
);
  import plc_pkg::*;

  localparam int unsigned OFF_W  = 6;
  localparam int unsigned BYTES  = 1 << OFF_W;
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  plc_state_e state;
  logic [PAGE_W-1:0] page_q;

  logic              evt;
  logic [ADDR_W-1:0] evt_addr;
  logic [DATA_W-1:0] evt_data;
  logic [OFF_W-1:0]  evt_off;
  logic [PAGE_W-1:0] evt_page;

  logic por_done, win_exp, prog_exp;
  logic accept, mismatch, close_w, fire;
  logic allow;

  logic [BYTES-1:0]        vmask;
  logic [BYTES*DATA_W-1:0] bdata;

  assign evt_off  = OFF_W'(byte_sel(32'(evt_addr), OFF_W));
  assign evt_page = PAGE_W'(page_sel(32'(evt_addr), OFF_W));

  assign accept   = evt && (state == ST_IDLE || (state == ST_LOAD && evt_page == page_q));
  assign mismatch = evt && state == ST_LOAD && evt_page != page_q;
  assign close_w  = state == ST_LOAD && !accept && win_exp;
  assign fire     = state == ST_PROG && prog_exp;
  assign allow    = por_done && state != ST_PROG;
  assign busy     = state == ST_PROG;

  plc_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .allow(allow), .addr(addr), .din(din),
    .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data)
  );

  plc_timer #(.LEN(T_POR), .START_FULL(1'b1)) u_por (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .run(1'b1), .expired(por_done)
  );

  plc_timer #(.LEN(T_BLC), .START_FULL(1'b0)) u_win (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(state == ST_LOAD), .expired(win_exp)
  );

  plc_timer #(.LEN(T_WC), .START_FULL(1'b0)) u_prog (
    .clk(clk), .rst_n(rst_n), .load(close_w), .run(state == ST_PROG), .expired(prog_exp)
  );

  plc_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(accept), .wr_off(evt_off), .wr_data(evt_data),
    .clr(fire), .vmask(vmask), .bdata(bdata)
  );

  plc_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(fire), .cpage(page_q), .cmask(vmask),
    .cdata(bdata), .raddr(addr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      page_q    <= '0;
      page_err  <= 1'b0;
      prog_done <= 1'b0;
    end else begin
      prog_done <= fire;
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_LOAD;
          page_q   <= evt_page;
          page_err <= 1'b0;
        end
        ST_LOAD: begin
          if (mismatch) page_err <= 1'b1;
          if (close_w) state <= ST_PROG;
        end
        ST_PROG: if (fire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  win_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(win_exp));

  // R5
  perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_err) |-> ($past(evt) && $past(state == ST_LOAD)));

  // R6
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> $stable(vmask));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !prog_done);

  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> (!busy && $past(busy) && vmask == '0));

  // R9
  por_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |-> (state == ST_IDLE && !page_err));
endmodule

// File: tb/tb_eeprom_page_loader.sv
module tb_eeprom_page_loader;
  localparam int AW = 11, DW = 8, T_BLC = 40, T_WC = 120, T_POR = 60;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] rdata;
  logic busy, prog_done, page_err;

  eeprom_page_loader #(.ADDR_W(AW), .DATA_W(DW), .T_BLC(T_BLC), .T_WC(T_WC), .T_POR(T_POR)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .rdata(rdata), .busy(busy), .prog_done(prog_done), .page_err(page_err)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, last_acc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] ref_mem [DEPTH];
  logic [7:0] pb [64];
  bit         pv [64];
  int         pend_page = -1;

  function automatic int pg(input int a); return a >> 6; endfunction
  function automatic int off(input int a); return a & 63; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mode 0: CE first, WE falls last, WE rises first; 1: swapped; 2: together
  task automatic strobe_w(input int a, input logic [7:0] d, input int mode, input bit track);
    @(negedge clk);
    addr = AW'(~a); oe_n = 1'b1;
    if (mode == 0) ce_n = 1'b0; else if (mode == 1) we_n = 1'b0;
    @(negedge clk);
    addr = AW'(a); din = ~d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = AW'(a + 17); din = d ^ 8'h5A;
    @(negedge clk);
    din = d;
    if (mode == 0) we_n = 1'b1; else if (mode == 1) ce_n = 1'b1; else begin we_n = 1'b1; ce_n = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; din = 8'h00; addr = AW'(a + 33);
    if (track) begin
      last_acc = cyc;
      if (pend_page < 0) pend_page = pg(a);
      pb[off(a)] = d; pv[off(a)] = 1'b1;
    end
  endtask

  task automatic commit_ref();
    for (int i = 0; i < 64; i++) begin
      if (pv[i]) ref_mem[pend_page*64 + i] = pb[i];
      pv[i] = 1'b0;
    end
    pend_page = -1;
  endtask

  // R4 R6 R8 timing of the close; optional strobe while busy
  task automatic close_check(input bit poke, input int poke_a);
    while (cyc < last_acc + T_BLC) @(negedge clk);
    chk(busy == 1'b0, "R4 busy before window end", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R4 busy after window end", busy, 1);
    if (poke) begin
      strobe_w(poke_a, 8'h3C, 2, 1'b0);
      repeat (T_WC - 1 - 5) @(negedge clk);
    end else begin
      repeat (T_WC - 1) @(negedge clk);
    end
    chk(busy == 1'b1, "R6 busy last cycle", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R6 busy length", busy, 0);
    chk(prog_done == 1'b1, "R8 done pulse", prog_done, 1);
    @(negedge clk);
    chk(prog_done == 1'b0, "R8 done width", prog_done, 0);
    commit_ref();
  endtask

  task automatic read_chk(input int a, input string tag);
    @(negedge clk);
    addr = AW'(a); we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk(rdata == ref_mem[a], tag, rdata, ref_mem[a]);
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic verify_page(input int p);
    for (int i = 0; i < 64; i++) read_chk(p*64 + i, "R7 R3 R11 page byte");
  endtask

  task automatic idle_check(input string tag);
    bit seen = 0;
    repeat (T_BLC + 8) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < DEPTH; k++) ref_mem[k] = 8'hFF;
    for (int i = 0; i < 64; i++) pv[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0, "R10 busy reset", busy, 0);
    chk(prog_done == 1'b0, "R10 done reset", prog_done, 0);
    chk(page_err == 1'b0, "R10 perr reset", page_err, 0);
    rst_n = 1'b1;

    // R9 strobe inside power-on delay is dropped
    strobe_w(70, 8'hA1, 2, 1'b0);
    idle_check("R9 no load during power-on delay");
    read_chk(70, "R9 byte unchanged");
    read_chk(5, "R10 erased value");
    repeat (T_POR) @(negedge clk);

    // R1 OE low inhibits the strobe
    @(negedge clk);
    addr = AW'(200); din = 8'h11; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    idle_check("R1 oe low blocks write");
    read_chk(200, "R1 byte unchanged");

    // R2 R3 directed: each mode, out of order, rewrite
    strobe_w(3*64 + 10, 8'h10, 0, 1'b1);
    strobe_w(3*64 + 2,  8'h22, 1, 1'b1);
    strobe_w(3*64 + 10, 8'h99, 2, 1'b1);
    strobe_w(3*64 + 63, 8'h7E, 0, 1'b1);
    close_check(1'b0, 0);
    read_chk(3*64 + 10, "R3 last value wins");
    read_chk(3*64 + 2, "R2 latch points");
    verify_page(3);
    read_chk(4*64 + 10, "R7 neighbour page");

    // R5 foreign page strobe: discarded, flag set, window not restarted
    strobe_w(7*64 + 1, 8'h41, 1, 1'b1);
    strobe_w(9*64 + 1, 8'hEE, 2, 1'b0);
    @(negedge clk);
    chk(page_err == 1'b1, "R5 page_err set", page_err, 1);
    close_check(1'b1, 12*64 + 4);
    chk(page_err == 1'b1, "R5 page_err sticky", page_err, 1);
    read_chk(9*64 + 1, "R5 foreign byte dropped");
    read_chk(7*64 + 1, "R5 good byte kept");
    // R6 strobe made while busy left nothing behind
    idle_check("R6 no load after busy strobe");
    read_chk(12*64 + 4, "R6 busy strobe ignored");

    // R5 cleared by first byte of next load
    strobe_w(1*64 + 5, 8'h05, 0, 1'b1);
    @(negedge clk);
    chk(page_err == 1'b0, "R5 page_err cleared", page_err, 0);
    close_check(1'b0, 0);
    verify_page(1);

    // random loads
    for (int r = 0; r < 6; r++) begin
      int p = $urandom_range(31, 0);
      int n = $urandom_range(12, 1);
      for (int j = 0; j < n; j++) begin
        int o = (j > 0 && $urandom_range(3, 0) == 0) ? 5 : $urandom_range(63, 0);
        strobe_w(p*64 + o, 8'($urandom()), $urandom_range(2, 0), 1'b1);
        repeat ($urandom_range(T_BLC - 10, 0)) @(negedge clk);
      end
      close_check(1'b0, 0);
      verify_page(p);
      read_chk(((p + 1) % 32)*64 + $urandom_range(63, 0), "R7 other page");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule